// File: doc/BRIEF.md
# Eight-Channel Timer Register Front End

This block is the bus-facing register file for a bank of eight timer channels. A single-cycle register bus supplies a byte address, a write enable and 32-bit write data. Read data is combinational from the address. Each channel owns a group of four 32-bit registers. The block decodes channel accesses into per-register write strobes and returns the channel's own readback word. The counting logic lives in the channels. Writes to a channel register take their data straight from `wdata_i`.

A shared group holds four words: the control word, the sticky interrupt status, the clear-lock key and the control-clear port. The shared group sits between channel 2 and channel 3 in the address map. Every control change is applied to the channels through a per-channel sequencer. A channel that is being switched off sees its enable drop while its three configuration bits still hold their old values. A channel that is being switched on first receives its new configuration with enable still low, and is enabled one cycle later.

Parameter `LOCK_CLR` selects the variant. At 0 the control-clear port always acts. At 1 the control-clear port acts only while an unlock flag is set, and that flag is written through a key word.

Top module: `tmr_bank_regs`

## Requirements
- R1: Byte addresses are decoded with bits [1:0] ignored. Group g = addr[11:4] and word index = addr[3:2]. Groups 0 to 2 map to channels 0 to 2, and groups 4 to 8 map to channels 3 to 7 (channel = g - 1). A read of a channel word returns `ch_rdata_i[(ch*4+idx)*32 +: 32]`.
- R2: A write to a channel word raises exactly `ch_we_o[ch*4+idx]` combinationally in the same cycle. No strobe is raised without `wr_i` or for a non-channel address.
- R3: Offset 0x30 is the control word, read and written whole. Channel i uses bits [4i+3:4i], and bit 4i is that channel's enable. The control word changes only on a bus write.
- R4: When a channel's enable goes from 1 to 0, `ctrl_o` for that channel shows {old config, 0} at the first edge after the write edge and the target value at the second edge.
- R5: When a channel's enable goes from 0 to 1 together with a configuration change, `ctrl_o` shows {new config, 0} at the first edge after the write edge and the target value at the second edge.
- R6: In every other case (enable unchanged, or enable rising with the same configuration), `ctrl_o` reaches the target at the first edge after the write edge.
- R7: A high `ch_evt_i[i]` at a clock edge sets status bit i, which reads at offset 0x34 bits [7:0]. Status bits do not drop without a write.
- R8: Writing ones at 0x34 clears those status bits. An event in the same cycle as the clear leaves its bit set.
- R9: Writing ones at 0x3C clears the matching control bits and the result is sequenced as in R4 to R6. With `LOCK_CLR`=0 this always acts.
- R10: With `LOCK_CLR`=1, a write at 0x38 sets the unlock flag when wdata[8:1] = 0xAE and clears it when wdata[8:1] = 0xEA. Other values leave the flag unchanged. 0x38 reads the flag in bit 0. A write at 0x3C while the flag is clear has no effect.
- R11: Unmapped offsets read as zero and ignore writes. These are groups above 8, 0x3C on read, and 0x38 when `LOCK_CLR`=0.
- R12: The asynchronous reset clears the control word, `ctrl_o`, the interrupt status and the unlock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address |
| wr_i | input | 1 | Write enable for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| ctrl_o | output | 32 | Sequenced control nibbles, channel i in [4i+3:4i] |
| ch_we_o | output | 32 | Per-channel register write strobes, bit ch*4+idx |
| ch_rdata_i | input | 1024 | Channel readback words, word ch*4+idx |
| ch_evt_i | input | 8 | Per-channel interrupt event pulses |

## Verification
The assertions assume that `addr_i`, `wr_i` and `wdata_i` are stable around each rising edge. They also assume that `ch_evt_i` changes only between edges and is low while reset is held. The stimulus drives every input at the falling edge and keeps events low across both reset phases. Random control and clear words are followed by two idle cycles before the next control write. This lets the settled-state expectations of R4 to R6 hold, while the sequencer properties still cover arbitrary nibble transitions. Two instances, one for each `LOCK_CLR` value, see identical traffic, so that the gated and ungated clear paths can be compared directly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SH_CTRL = 2'd0,
    SH_STS  = 2'd1,
    SH_KEY  = 2'd2,
    SH_CLR  = 2'd3
  } sh_reg_e;

  localparam logic [7:0] KEY_OPEN = 8'hAE;
  localparam logic [7:0] KEY_SHUT = 8'hEA;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec #(
  parameter int AW        = 12,
  parameter int N_CH      = 8,
  parameter int SPLIT_GRP = 3,
  parameter int CH_W      = $clog2(N_CH)
) (
  input  logic [AW-3:0]   word_addr_i,
  output logic            ch_hit_o,
  output logic            sh_hit_o,
  output logic [CH_W-1:0] ch_idx_o,
  output logic [1:0]      reg_idx_o
);
  localparam int GRP_W = AW - 4;
  localparam logic [GRP_W-1:0] SPLIT = GRP_W'(SPLIT_GRP);
  localparam logic [GRP_W-1:0] NCH   = GRP_W'(N_CH);

  logic [GRP_W-1:0] grp, sel;

  assign grp       = word_addr_i[AW-3:2];
  assign reg_idx_o = word_addr_i[1:0];

  always_comb begin
    ch_hit_o = 1'b0;
    sh_hit_o = 1'b0;
    sel      = grp;
    if (grp < SPLIT) begin
      ch_hit_o = 1'b1;
    end else if (grp == SPLIT) begin
      sh_hit_o = 1'b1;
    end else begin
      // groups above the shared one are shifted down by one channel
      sel      = grp - GRP_W'(1);
      ch_hit_o = (sel < NCH);
    end
  end

  assign ch_idx_o = sel[CH_W-1:0];
endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] tgt_i,
  output logic [CW-1:0] app_o
);
  logic [CW-1:0] app_q, app_d;

  // bit 0 is enable; config is [CW-1:1]
  always_comb begin
    if (app_q[0] && !tgt_i[0])
      app_d = {app_q[CW-1:1], 1'b0};
    else if (!app_q[0] && tgt_i[0] && (app_q[CW-1:1] != tgt_i[CW-1:1]))
      app_d = {tgt_i[CW-1:1], 1'b0};
    else
      app_d = tgt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) app_q <= '0;
    else         app_q <= app_d;
  end

  assign app_o = app_q;
endmodule

// File: rtl/tmr_irq_stat.sv
module tmr_irq_stat #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | evt_i;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/tmr_bank_regs.sv
module tmr_bank_regs #(
  parameter int N_CH      = 8,
  parameter int CW        = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int SPLIT_GRP = 3,
  parameter bit LOCK_CLR  = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        wr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [N_CH*CW-1:0]          ctrl_o,
  output logic [N_CH*4-1:0]           ch_we_o,
  input  logic [N_CH*4*DATA_W-1:0]    ch_rdata_i,
  input  logic [N_CH-1:0]             ch_evt_i
);
  import tmr_pkg::*;

  localparam int CTRL_W = N_CH * CW;
  localparam int CH_W   = $clog2(N_CH);
  localparam int N_WORD = N_CH * 4;

  logic            ch_hit, sh_hit;
  logic [CH_W-1:0] ch_idx;
  logic [1:0]      reg_idx;
  logic            wr_ctl, wr_sts, wr_key, wr_clr;
  logic            unlock_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [N_CH-1:0] sts_w, sts_clr;
  logic [DATA_W-1:0] rb_w [N_WORD];
  logic [CH_W+1:0] widx;
  logic            unused_lsb;

  assign unused_lsb = ^addr_i[1:0];

  tmr_addr_dec #(
    .AW(ADDR_W), .N_CH(N_CH), .SPLIT_GRP(SPLIT_GRP), .CH_W(CH_W)
  ) u_dec (
    .word_addr_i (addr_i[ADDR_W-1:2]),
    .ch_hit_o    (ch_hit),
    .sh_hit_o    (sh_hit),
    .ch_idx_o    (ch_idx),
    .reg_idx_o   (reg_idx)
  );

  // channel write strobes
  for (genvar c = 0; c < N_CH; c++) begin : g_we
    for (genvar r = 0; r < 4; r++) begin : g_reg
      assign ch_we_o[c*4+r] = wr_i && ch_hit &&
                              (ch_idx == CH_W'(c)) && (reg_idx == 2'(r));
    end
  end

  assign wr_ctl = wr_i && sh_hit && (reg_idx == SH_CTRL);
  assign wr_sts = wr_i && sh_hit && (reg_idx == SH_STS);
  assign wr_key = LOCK_CLR && wr_i && sh_hit && (reg_idx == SH_KEY);
  assign wr_clr = wr_i && sh_hit && (reg_idx == SH_CLR) && (!LOCK_CLR || unlock_q);

  // clear-lock flag
  if (LOCK_CLR) begin : g_lock
    logic unlock_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        unlock_r <= 1'b0;
      else if (wr_key) begin
        if (wdata_i[8:1] == KEY_OPEN)      unlock_r <= 1'b1;
        else if (wdata_i[8:1] == KEY_SHUT) unlock_r <= 1'b0;
      end
    end
    assign unlock_q = unlock_r;
  end else begin : g_open
    assign unlock_q = 1'b0;
  end

  // architectural control word
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctl)      ctrl_d = wdata_i[CTRL_W-1:0];
    else if (wr_clr) ctrl_d = ctrl_q & ~wdata_i[CTRL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_seq
    tmr_ctrl_seq #(.CW(CW)) u_seq (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tgt_i (ctrl_q[c*CW +: CW]),
      .app_o (ctrl_o[c*CW +: CW])
    );
  end

  assign sts_clr = wr_sts ? wdata_i[N_CH-1:0] : '0;

  tmr_irq_stat #(.N(N_CH)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (ch_evt_i),
    .clr_i (sts_clr),
    .sts_o (sts_w)
  );

  // read mux
  for (genvar k = 0; k < N_WORD; k++) begin : g_rb
    assign rb_w[k] = ch_rdata_i[k*DATA_W +: DATA_W];
  end

  assign widx = {ch_idx, reg_idx};

  always_comb begin
    rdata_o = '0;
    if (ch_hit) begin
      rdata_o = rb_w[widx];
    end else if (sh_hit) begin
      unique case (reg_idx)
        SH_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
        SH_STS:  rdata_o[N_CH-1:0]   = sts_w;
        SH_KEY:  rdata_o[0]          = unlock_q;
        default: rdata_o             = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_bank_regs_chk.sv
module tmr_bank_regs_chk #(
  parameter int N_CH      = 8,
  parameter int CW        = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int SPLIT_GRP = 3,
  parameter bit LOCK_CLR  = 1'b1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-3:0]     waddr_i,
  input logic                  wr_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [N_CH*CW-1:0]    ctrl_o,
  input logic [N_CH*4-1:0]     ch_we_o,
  input logic [N_CH-1:0]       ch_evt_i,
  input logic [N_CH-1:0]       sts_q,
  input logic [N_CH*CW-1:0]    ctrl_q,
  input logic                  unlock_q
);
  localparam logic [ADDR_W-3:0] CLR_WORD = (ADDR_W-2)'(SPLIT_GRP*4 + 3);
  localparam logic [ADDR_W-5:0] LAST_GRP = (ADDR_W-4)'(N_CH);

  p_we_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_we_o));

  p_we_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> (ch_we_o == '0));

  p_ctrl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    p_dis_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ctrl_o[c*CW]) |-> $stable(ctrl_o[c*CW+1 +: CW-1]));
    p_en_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ctrl_o[c*CW]) |-> $stable(ctrl_o[c*CW+1 +: CW-1]));
  end

  p_evt_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_evt_i != '0) |=> ((sts_q & $past(ch_evt_i)) == $past(ch_evt_i)));

  p_sts_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  p_locked_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LOCK_CLR && !unlock_q && wr_i && (waddr_i == CLR_WORD)) |=> $stable(ctrl_q));

  p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waddr_i[ADDR_W-3:2] > LAST_GRP) |-> (rdata_o == '0));
endmodule

bind tmr_bank_regs tmr_bank_regs_chk #(
  .N_CH(N_CH), .CW(CW), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .SPLIT_GRP(SPLIT_GRP), .LOCK_CLR(LOCK_CLR)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .waddr_i (addr_i[ADDR_W-1:2]),
  .wr_i    (wr_i),
  .rdata_o (rdata_o),
  .ctrl_o  (ctrl_o),
  .ch_we_o (ch_we_o),
  .ch_evt_i(ch_evt_i),
  .sts_q   (sts_w),
  .ctrl_q  (ctrl_q),
  .unlock_q(unlock_q)
);

// File: tb/tmr_bank_regs_tb.sv
module tmr_bank_regs_tb;
  localparam int N_CH = 8;
  localparam int DW   = 32;
  localparam int AW   = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [AW-1:0]     addr;
  logic              wr;
  logic [DW-1:0]     wdata;
  logic [N_CH*4*DW-1:0] ch_rdata;
  logic [N_CH-1:0]   evt;
  logic [DW-1:0]     rd_l, rd_o, ctl_l, ctl_o, we_l, we_o;

  tmr_bank_regs #(.LOCK_CLR(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rd_l), .ctrl_o(ctl_l), .ch_we_o(we_l),
    .ch_rdata_i(ch_rdata), .ch_evt_i(evt));

  tmr_bank_regs #(.LOCK_CLR(1'b0)) u_dut_open (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rd_o), .ctrl_o(ctl_o), .ch_we_o(we_o),
    .ch_rdata_i(ch_rdata), .ch_evt_i(evt));

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [DW-1:0] rbw [N_CH*4];
  logic [DW-1:0] m_ctl_l, m_ctl_o, m_sts;
  logic          m_unl;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int grp_of(input int ch);
    return (ch < 3) ? ch : ch + 1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a, input bit lk);
    int g = int'(a[11:4]);
    int i = int'(a[3:2]);
    if (g < 3) return rbw[g*4+i];
    if (g == 3) begin
      case (i)
        0: return lk ? m_ctl_l : m_ctl_o;
        1: return m_sts;
        2: return lk ? {31'b0, m_unl} : 32'h0;
        default: return 32'h0;
      endcase
    end
    if (g <= 8) return rbw[(g-1)*4+i];
    return 32'h0;
  endfunction

  function automatic string rd_req(input logic [AW-1:0] a);
    int g = int'(a[11:4]);
    if (g > 8) return "R11";
    if (g == 3) return (a[3:2] == 2'd3) ? "R11" : "R3";
    return "R1";
  endfunction

  // expected applied nibbles one edge after a control change
  function automatic logic [31:0] step(input logic [31:0] cur, input logic [31:0] tgt);
    logic [31:0] r;
    for (int c = 0; c < N_CH; c++) begin
      logic [3:0] o, t;
      o = cur[c*4 +: 4];
      t = tgt[c*4 +: 4];
      if (o[0] && !t[0])                         r[c*4 +: 4] = {o[3:1], 1'b0};
      else if (!o[0] && t[0] && o[3:1] != t[3:1]) r[c*4 +: 4] = {t[3:1], 1'b0};
      else                                        r[c*4 +: 4] = t;
    end
    return r;
  endfunction

  task automatic wr_op(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    addr = a; wr = 1'b0;
    #1;
    chk(req, rd_l, exp_rd(a, 1'b1));
    chk(req, rd_o, exp_rd(a, 1'b0));
  endtask

  task automatic do_ctl(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string rl, input string ro);
    logic [31:0] nl, no;
    if (a == 12'h030) begin
      nl = d; no = d;
    end else begin
      nl = m_unl ? (m_ctl_l & ~d) : m_ctl_l;
      no = m_ctl_o & ~d;
    end
    wr_op(a, d);
    @(negedge clk);
    chk(rl, ctl_l, step(m_ctl_l, nl));
    chk(ro, ctl_o, step(m_ctl_o, no));
    @(negedge clk);
    chk(rl, ctl_l, nl);
    chk(ro, ctl_o, no);
    m_ctl_l = nl;
    m_ctl_o = no;
    rd_chk(12'h030, "R3");
  endtask

  task automatic key_wr(input logic [DW-1:0] d);
    wr_op(12'h038, d);
    if (d[8:1] == 8'hAE) m_unl = 1'b1;
    else if (d[8:1] == 8'hEA) m_unl = 1'b0;
    rd_chk(12'h038, "R10");
  endtask

  initial begin
    #(8*200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_1234);
    rst_n = 1'b0; addr = '0; wr = 1'b0; wdata = '0; evt = '0;
    m_ctl_l = '0; m_ctl_o = '0; m_sts = '0; m_unl = 1'b0;
    for (int k = 0; k < N_CH*4; k++) begin
      rbw[k] = $urandom;
      ch_rdata[k*DW +: DW] = rbw[k];
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", ctl_l, 32'h0);
    chk("R12", ctl_o, 32'h0);
    rd_chk(12'h030, "R12");
    rd_chk(12'h034, "R12");
    rd_chk(12'h038, "R12");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 directed boundaries and random reads
    rd_chk(12'h02C, "R1");
    rd_chk(12'h040, "R1");
    rd_chk(12'h08F, "R1");
    rd_chk(12'h090, "R11");
    rd_chk(12'h03C, "R11");
    for (int n = 0; n < 200; n++) begin
      logic [AW-1:0] a;
      a = (n % 8 == 0) ? AW'($urandom) : AW'($urandom_range(0, 'h9F));
      rd_chk(a, rd_req(a));
    end

    // R2 channel write strobes
    for (int n = 0; n < 100; n++) begin
      int ch, ix;
      logic [AW-1:0] a;
      ch = $urandom_range(0, 7);
      ix = $urandom_range(0, 3);
      a = AW'(grp_of(ch) * 16 + ix * 4 + $urandom_range(0, 3));
      @(negedge clk);
      addr = a; wdata = $urandom; wr = 1'b1;
      #1;
      chk("R2", we_l, 32'h1 << (ch*4 + ix));
      chk("R2", we_o, 32'h1 << (ch*4 + ix));
      @(negedge clk);
      wr = 1'b0;
      #1;
      chk("R2", we_l, 32'h0);
    end
    // unmapped write: no strobe, no state change
    @(negedge clk);
    addr = 12'h094; wdata = 32'hFFFF_FFFF; wr = 1'b1;
    #1;
    chk("R11", we_l, 32'h0);
    @(negedge clk);
    wr = 1'b0;
    rd_chk(12'h030, "R11");
    rd_chk(12'h034, "R11");

    // ordering on channel 2 (nibble [11:8])
    do_ctl(12'h030, 32'h0000_0700, "R5", "R5");
    do_ctl(12'h030, 32'h0000_0A00, "R4", "R4");
    do_ctl(12'h030, 32'h0000_0B00, "R6", "R6");
    do_ctl(12'h030, 32'h0000_0500, "R6", "R6");
    do_ctl(12'h03C, 32'h0000_0F00, "R10", "R9");
    key_wr(32'h0000_015C);
    do_ctl(12'h03C, 32'h0000_0F00, "R9", "R9");
    key_wr(32'h0000_0002);
    key_wr(32'h0000_01D4);
    key_wr(32'h0000_0000);
    do_ctl(12'h030, 32'h0000_0300, "R5", "R5");
    do_ctl(12'h03C, 32'h0000_0100, "R10", "R9");

    // random control and clear traffic
    for (int n = 0; n < 60; n++) begin
      if (n % 3 == 2) begin
        if (n % 6 == 5) key_wr(32'h0000_015C);
        do_ctl(12'h03C, $urandom, m_unl ? "R9" : "R10", "R9");
        if (m_unl) key_wr(32'h0000_01D4);
      end else begin
        do_ctl(12'h030, $urandom, "R6", "R6");
      end
    end

    // status: events and write-one-to-clear
    for (int n = 0; n < 80; n++) begin
      logic [7:0] e;
      logic [31:0] c;
      bit dc;
      e = 8'($urandom) & 8'($urandom);
      c = $urandom;
      dc = 1'($urandom);
      @(negedge clk);
      evt = e;
      if (dc) begin addr = 12'h034; wdata = c; wr = 1'b1; end
      @(negedge clk);
      evt = '0; wr = 1'b0;
      m_sts = (m_sts & ~(dc ? {24'h0, c[7:0]} : 32'h0)) | {24'h0, e};
      rd_chk(12'h034, dc ? "R8" : "R7");
    end
    // event and clear on the same bit in the same cycle
    @(negedge clk);
    evt = 8'h08; addr = 12'h034; wdata = 32'hFF; wr = 1'b1;
    @(negedge clk);
    evt = '0; wr = 1'b0;
    m_sts = 32'h08;
    rd_chk(12'h034, "R8");
    wr_op(12'h034, 32'hFF);
    m_sts = 32'h0;
    rd_chk(12'h034, "R8");

    // R12: reset with state present
    do_ctl(12'h030, 32'h1357_9BDF, "R6", "R6");
    key_wr(32'h0000_015C);
    @(negedge clk); evt = 8'hA5;
    @(negedge clk); evt = '0;
    m_sts = 32'hA5;
    rd_chk(12'h034, "R7");
    rst_n = 1'b0;
    m_ctl_l = '0; m_ctl_o = '0; m_sts = '0; m_unl = 1'b0;
    #1;
    chk("R12", ctl_l, 32'h0);
    chk("R12", ctl_o, 32'h0);
    rd_chk(12'h030, "R12");
    rd_chk(12'h034, "R12");
    rd_chk(12'h038, "R12");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule